// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Copy Engine

This block moves a run of data words from one memory-mapped slave to another without processor involvement. Software loads a source address, a destination address and a byte count through a small configuration port, then writes a control word with the start bit set. The engine reads one word from the source side, waits for the returned data, writes it to the destination side, and repeats until the byte count runs out.

The source address can either advance by the beat size after each word or stay pinned, so a FIFO-like slave can be drained into a buffer. The destination address can be pinned the same way. A beat-size field picks 1, 2 or 4 bytes per beat. The remaining count drops by that size for each word written. There is only ever one read in flight, and no read is issued while a write is pending.

When the count is used up, the engine returns to idle and raises two status flags: one reports completion and one reports that the count reached zero.

Top module: `mm_copy_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the source, destination, length and control registers and the status flags, returns the sequencer to idle and drops `rd_req` and `wr_req`. This also applies in the middle of a transfer.
- R2: A configuration write with bit 0 set to offset 3 starts a transfer if the engine is idle and the length is non-zero. From the next cycle, status bit 1 (busy) reads 1. After the last accepted write, busy reads 0, bit 0 (done) reads 1 and bit 2 (count-zero) reads 1.
- R3: A transfer moves exactly ceil(length / beat) words, with exactly one accepted read request per word. The length register drops by the beat size on each accepted write, saturates at zero, and reads 0 at the end.
- R4: Control bit 1 pins the source address. Otherwise the source address advances by the beat size after each accepted read. Control bit 2 pins the destination address. Otherwise the destination address advances by the beat size after each accepted write. Offsets 0 and 1 read back the current addresses.
- R5: While `rd_wait` is high, `rd_req` and `rd_addr` hold. While `wr_wait` is high, `wr_req`, `wr_addr` and `wr_data` hold. Read data is taken only in a cycle with `rd_valid` high. `rd_req` and `wr_req` are never high together.
- R6: Control bits 5:4 select the beat size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. `wr_be` asserts the low lanes equal in number to the beat size, so a 4-byte beat sets every lane.
- R7: Writing status (offset 4) with bit 0 set clears done and leaves count-zero unchanged. While busy, every configuration write is ignored, including a new start.
- R8: Starting with a length of 0 sets done and count-zero by the next cycle. It never sets busy and issues no read or write.
- R9: Configuration reads are combinational. Offset 0 returns the source address, 1 the destination address, 2 the remaining length, 3 the control word with bit 0 reading 0, and 4 the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| rd_req | output | 1 | Read request to source slave |
| rd_addr | output | ADDR_W | Source byte address |
| rd_wait | input | 1 | Source slave stall |
| rd_valid | input | 1 | Source read data valid |
| rd_data | input | DATA_W | Source read data |
| wr_req | output | 1 | Write request to destination slave |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_data | output | DATA_W | Destination write data |
| wr_be | output | DATA_W/8 | Destination byte enables |
| wr_wait | input | 1 | Destination slave stall |

## Verification
The copy path is run with several input patterns. A single-word copy and a pinned-source copy of 8 bytes tell a correct multi-word sequencer apart from one that stops after the first word or stays busy. Copies with read and write stalls and read latencies of one to three cycles test the hold rules and show that stale read data (driven as a marker value when `rd_valid` is low) is never written. Copies with lengths that do not divide by the beat size, with 1-, 2- and 4-byte beats and with pinned destinations, test the rounded word count, the saturating length and the byte-enable pattern.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD    = 2'd1,
      ST_RWAIT = 2'd2,
      ST_WR    = 2'd3
   } seq_state_e;

   localparam logic [2:0] OFS_SRC  = 3'd0;
   localparam logic [2:0] OFS_DST  = 3'd1;
   localparam logic [2:0] OFS_LEN  = 3'd2;
   localparam logic [2:0] OFS_CTRL = 3'd3;
   localparam logic [2:0] OFS_STAT = 3'd4;

   localparam int CB_GO      = 0;
   localparam int CB_SRC_PIN = 1;
   localparam int CB_DST_PIN = 2;
   localparam int CB_SIZE_LO = 4;

   function automatic logic [2:0] beat_bytes(input logic [1:0] sel);
      case (sel)
         2'd0:    beat_bytes = 3'd1;
         2'd1:    beat_bytes = 3'd2;
         default: beat_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_copy_actr.sv
module dma_copy_actr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv,
   input  logic              hold,
   input  logic [2:0]        step,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= load_val;
      else if (adv && !hold)
         q <= q + ADDR_W'(step);
   end

   AST_PINNED_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
      (adv && hold && !load) |=> $stable(q)); // R4

endmodule

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
   import dma_copy_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int CFG_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        cfg_addr,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic              lenz,
   input  logic [ADDR_W-1:0] src_q,
   input  logic [ADDR_W-1:0] dst_q,
   input  logic [LEN_W-1:0]  len_q,
   output logic              src_ld,
   output logic              dst_ld,
   output logic              len_ld,
   output logic              go,
   output logic              done_clr,
   output logic              src_pin,
   output logic              dst_pin,
   output logic [1:0]        size_sel
);

   logic wr_ok;
   assign wr_ok    = cfg_wr && !busy;
   assign src_ld   = wr_ok && (cfg_addr == OFS_SRC);
   assign dst_ld   = wr_ok && (cfg_addr == OFS_DST);
   assign len_ld   = wr_ok && (cfg_addr == OFS_LEN);
   assign go       = wr_ok && (cfg_addr == OFS_CTRL) && cfg_wdata[CB_GO];
   assign done_clr = wr_ok && (cfg_addr == OFS_STAT) && cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         src_pin  <= 1'b0;
         dst_pin  <= 1'b0;
         size_sel <= 2'd0;
      end else if (wr_ok && (cfg_addr == OFS_CTRL)) begin
         src_pin  <= cfg_wdata[CB_SRC_PIN];
         dst_pin  <= cfg_wdata[CB_DST_PIN];
         size_sel <= cfg_wdata[CB_SIZE_LO +: 2];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         OFS_SRC:  cfg_rdata[ADDR_W-1:0] = src_q;
         OFS_DST:  cfg_rdata[ADDR_W-1:0] = dst_q;
         OFS_LEN:  cfg_rdata[LEN_W-1:0]  = len_q;
         OFS_CTRL: begin
            cfg_rdata[CB_SRC_PIN]      = src_pin;
            cfg_rdata[CB_DST_PIN]      = dst_pin;
            cfg_rdata[CB_SIZE_LO +: 2] = size_sel;
         end
         OFS_STAT: cfg_rdata[2:0] = {lenz, busy, done};
         default:  cfg_rdata = '0;
      endcase
   end

   AST_CTRL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(src_pin) && $stable(dst_pin) && $stable(size_sel))); // R7

endmodule

// File: rtl/dma_copy_seq.sv
module dma_copy_seq
   import dma_copy_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic              len_ld,
   input  logic [LEN_W-1:0]  len_wdata,
   input  logic [2:0]        step,
   input  logic              done_clr,
   input  logic              rd_wait,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wr_wait,
   output logic              rd_req,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output logic              src_adv,
   output logic              dst_adv,
   output logic              busy,
   output logic              done,
   output logic              lenz,
   output logic [LEN_W-1:0]  len_q
);

   seq_state_e state;
   logic [LEN_W-1:0] step_l;
   logic             last_beat;

   assign step_l    = LEN_W'(step);
   assign last_beat = (len_q <= step_l);
   assign rd_req    = (state == ST_RD);
   assign wr_req    = (state == ST_WR);
   assign busy      = (state != ST_IDLE);
   assign src_adv   = rd_req && !rd_wait;
   assign dst_adv   = wr_req && !wr_wait;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         done    <= 1'b0;
         lenz    <= 1'b0;
         len_q   <= '0;
         wr_data <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (len_ld)
                  len_q <= len_wdata;
               if (go) begin
                  if (len_q == '0) begin
                     done <= 1'b1;
                     lenz <= 1'b1;
                  end else begin
                     done  <= 1'b0;
                     lenz  <= 1'b0;
                     state <= ST_RD;
                  end
               end else if (done_clr) begin
                  done <= 1'b0;
               end
            end
            ST_RD: begin
               if (!rd_wait) begin
                  if (rd_valid) begin
                     wr_data <= rd_data;
                     state   <= ST_WR;
                  end else begin
                     state <= ST_RWAIT;
                  end
               end
            end
            ST_RWAIT: begin
               if (rd_valid) begin
                  wr_data <= rd_data;
                  state   <= ST_WR;
               end
            end
            ST_WR: begin
               if (!wr_wait) begin
                  len_q <= last_beat ? '0 : (len_q - step_l);
                  if (last_beat) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     lenz  <= 1'b1;
                  end else begin
                     state <= ST_RD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_ONE_SIDE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      !(rd_req && wr_req)); // R5
   AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
      !(busy && done)); // R2
   AST_LAST_WRITE_ENDS: assert property (@(posedge clk) disable iff (rst)
      (dst_adv && last_beat) |=> (!busy && done && lenz && len_q == '0)); // R2
   AST_ZERO_LEN_NO_BUS: assert property (@(posedge clk) disable iff (rst)
      (!busy && go && len_q == '0) |=> (!rd_req && !wr_req && done)); // R8

endmodule

// File: rtl/mm_copy_engine.sv
module mm_copy_engine
   import dma_copy_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          cfg_addr,
   input  logic                cfg_wr,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   output logic                rd_req,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic                rd_wait,
   input  logic                rd_valid,
   input  logic [DATA_W-1:0]   rd_data,
   output logic                wr_req,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W/8-1:0] wr_be,
   input  logic                wr_wait
);

   localparam int CFG_W = 32;
   localparam int LANES = DATA_W / 8;
   localparam int N_CTR = 2;

   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("mm_copy_engine: DATA_W must be a multiple of 8 and at least 32");
   end
   if (ADDR_W < 4 || ADDR_W > CFG_W) begin : g_bad_addr_w
      $error("mm_copy_engine: ADDR_W must lie in 4..32");
   end
   if (LEN_W < 4 || LEN_W > CFG_W) begin : g_bad_len_w
      $error("mm_copy_engine: LEN_W must lie in 4..32");
   end

   logic              src_ld, dst_ld, len_ld, go, done_clr;
   logic              src_pin, dst_pin;
   logic [1:0]        size_sel;
   logic [2:0]        beat;
   logic              busy, done, lenz, src_adv, dst_adv;
   logic [LEN_W-1:0]  len_q;

   logic              ctr_load [N_CTR];
   logic              ctr_adv  [N_CTR];
   logic              ctr_hold [N_CTR];
   logic [ADDR_W-1:0] ctr_q    [N_CTR];

   assign beat = beat_bytes(size_sel);

   assign ctr_load[0] = src_ld;
   assign ctr_adv[0]  = src_adv;
   assign ctr_hold[0] = src_pin;
   assign ctr_load[1] = dst_ld;
   assign ctr_adv[1]  = dst_adv;
   assign ctr_hold[1] = dst_pin;
   assign rd_addr     = ctr_q[0];
   assign wr_addr     = ctr_q[1];

   for (genvar gi = 0; gi < N_CTR; gi++) begin : g_ctr
      dma_copy_actr #(.ADDR_W(ADDR_W)) u_actr (
         .clk      (clk),
         .rst      (rst),
         .load     (ctr_load[gi]),
         .load_val (cfg_wdata[ADDR_W-1:0]),
         .adv      (ctr_adv[gi]),
         .hold     (ctr_hold[gi]),
         .step     (beat),
         .q        (ctr_q[gi])
      );
   end

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      assign wr_be[gl] = (32'(beat) > gl);
   end

   dma_copy_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .cfg_addr  (cfg_addr),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .busy      (busy),
      .done      (done),
      .lenz      (lenz),
      .src_q     (ctr_q[0]),
      .dst_q     (ctr_q[1]),
      .len_q     (len_q),
      .src_ld    (src_ld),
      .dst_ld    (dst_ld),
      .len_ld    (len_ld),
      .go        (go),
      .done_clr  (done_clr),
      .src_pin   (src_pin),
      .dst_pin   (dst_pin),
      .size_sel  (size_sel)
   );

   dma_copy_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .go        (go),
      .len_ld    (len_ld),
      .len_wdata (cfg_wdata[LEN_W-1:0]),
      .step      (beat),
      .done_clr  (done_clr),
      .rd_wait   (rd_wait),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .wr_wait   (wr_wait),
      .rd_req    (rd_req),
      .wr_req    (wr_req),
      .wr_data   (wr_data),
      .src_adv   (src_adv),
      .dst_adv   (dst_adv),
      .busy      (busy),
      .done      (done),
      .lenz      (lenz),
      .len_q     (len_q)
   );

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_wait) |=> (rd_req && $stable(rd_addr))); // R5
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_req && wr_wait) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R5
   AST_BE_LOW_LANES: assert property (@(posedge clk) disable iff (rst)
      wr_req |-> (wr_be[0] && $countones(wr_be) == 32'(beat))); // R6

endmodule

// File: tb/tb_mm_copy_engine.sv
`timescale 1ns/1ps
module tb_mm_copy_engine;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NV = 6;

   // {src, dst, len, src_pin, dst_pin, size, rd_stall, wr_stall, rd_lat}
   localparam logic [63:0] VECS [NV] = '{
      {16'h0100, 16'h2000, 16'h0004, 1'b0, 1'b0, 2'd2, 4'd0, 4'd0, 4'd1},
      {16'h0200, 16'h3000, 16'h0008, 1'b1, 1'b0, 2'd2, 4'd0, 4'd0, 4'd1},
      {16'h0300, 16'h3100, 16'h000A, 1'b0, 1'b0, 2'd2, 4'd2, 4'd1, 4'd3},
      {16'h0402, 16'h3200, 16'h0005, 1'b0, 1'b0, 2'd1, 4'd1, 4'd0, 4'd2},
      {16'h0503, 16'h3300, 16'h0003, 1'b0, 1'b1, 2'd0, 4'd0, 4'd2, 4'd1},
      {16'h0600, 16'h3400, 16'h0010, 1'b1, 1'b1, 2'd2, 4'd3, 4'd3, 4'd2}
   };

   logic          clk = 1'b0;
   logic          rst;
   logic [2:0]    cfg_addr;
   logic          cfg_wr;
   logic [31:0]   cfg_wdata;
   logic [31:0]   cfg_rdata;
   logic          rd_req, rd_wait, rd_valid;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          wr_req, wr_wait;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [3:0]    wr_be;

   always #2.5 clk = ~clk;

   mm_copy_engine dut (
      .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_wait(rd_wait),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .wr_wait(wr_wait)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // slave models
   int            rd_stall, wr_stall, rd_lat;
   int            rcnt, wcnt, vcnt;
   int            n_rd, n_wr;
   logic          log_clr;
   logic [AW-1:0] pend_addr;
   logic [AW-1:0] rd_log [64];
   logic [AW-1:0] wa_log [64];
   logic [DW-1:0] wd_log [64];
   logic [3:0]    wb_log [64];

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {~a[15:0], a[15:0]};
   endfunction

   assign rd_wait  = rd_req && (rcnt < rd_stall);
   assign wr_wait  = wr_req && (wcnt < wr_stall);
   assign rd_valid = (vcnt == 1);
   assign rd_data  = rd_valid ? pat(pend_addr) : 32'hDEAD_BEEF;

   always @(posedge clk) begin
      if (vcnt != 0) vcnt <= vcnt - 1;
      if (log_clr) begin
         n_rd <= 0; n_wr <= 0; rcnt <= 0; wcnt <= 0; vcnt <= 0;
      end else begin
         if (rd_req) begin
            if (rd_wait) rcnt <= rcnt + 1;
            else begin
               rcnt <= 0; pend_addr <= rd_addr; vcnt <= rd_lat;
               if (n_rd < 64) rd_log[n_rd] <= rd_addr;
               n_rd <= n_rd + 1;
            end
         end
         if (wr_req) begin
            if (wr_wait) wcnt <= wcnt + 1;
            else begin
               wcnt <= 0;
               if (n_wr < 64) begin
                  wa_log[n_wr] <= wr_addr; wd_log[n_wr] <= wr_data; wb_log[n_wr] <= wr_be;
               end
               n_wr <= n_wr + 1;
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #0.5;
      d = cfg_rdata;
   endtask

   task automatic wait_done(input string req);
      logic [31:0] s;
      int k;
      s = '0;
      k = 0;
      while (!s[0] && k < 2000) begin
         cfg_read(3'd4, s);
         k++;
      end
      if (!s[0]) chk(req, "transfer timeout", s, 32'h5);
   endtask

   task automatic clear_logs();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      rst = 1'b1; cfg_addr = '0; cfg_wr = 1'b0; cfg_wdata = '0; log_clr = 1'b1;
      rd_stall = 0; wr_stall = 0; rd_lat = 1;
      repeat (4) @(negedge clk);
      rst = 1'b0; log_clr = 1'b0;

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         cfg_read(3'(a), r);
         chk("R1", "reg after reset", r, 32'h0);
      end
      chk("R1", "rd_req after reset", 32'(rd_req), 32'h0);
      chk("R1", "wr_req after reset", 32'(wr_req), 32'h0);

      // vector table walk: R2 R3 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         logic [31:0] src, dst, len, ctl, step, words, be_exp;
         logic fs, fd;
         src = 32'(VECS[v][63:48]); dst = 32'(VECS[v][47:32]); len = 32'(VECS[v][31:16]);
         fs = VECS[v][15]; fd = VECS[v][14];
         step = (VECS[v][13:12] == 2'd0) ? 1 : (VECS[v][13:12] == 2'd1) ? 2 : 4;
         words = (len + step - 1) / step;
         be_exp = (32'h1 << step) - 1;
         rd_stall = int'(VECS[v][11:8]); wr_stall = int'(VECS[v][7:4]); rd_lat = int'(VECS[v][3:0]);
         clear_logs();
         cfg_write(3'd0, src);
         cfg_write(3'd1, dst);
         cfg_write(3'd2, len);
         ctl = {26'd0, VECS[v][13:12], 1'b0, fd, fs, 1'b0};
         cfg_write(3'd3, ctl | 32'h1);
         cfg_read(3'd4, r);
         chk("R2", "status while running", r & 32'h7, 32'h2);
         wait_done("R2");
         cfg_read(3'd4, r);
         chk("R2", "status at end", r, 32'h5);
         chk("R3", "read count", 32'(n_rd), words);
         chk("R3", "write count", 32'(n_wr), words);
         cfg_read(3'd2, r);
         chk("R3", "length left", r, 32'h0);
         cfg_read(3'd0, r);
         chk("R4", "final source", r, fs ? src : src + words * step);
         cfg_read(3'd1, r);
         chk("R4", "final dest", r, fd ? dst : dst + words * step);
         cfg_read(3'd3, r);
         chk("R9", "control readback", r, ctl);
         for (int k = 0; k < int'(words) && k < 64; k++) begin
            chk("R4", "read address", rd_log[k], fs ? src : src + 32'(k) * step);
            chk("R4", "write address", wa_log[k], fd ? dst : dst + 32'(k) * step);
            chk("R5", "write data", wd_log[k], pat(rd_log[k]));
            chk("R6", "byte enables", 32'(wb_log[k]), be_exp);
         end
      end

      // R8: zero length
      rd_stall = 0; wr_stall = 0; rd_lat = 1;
      clear_logs();
      cfg_write(3'd2, 32'h0);
      cfg_write(3'd3, 32'h21);
      cfg_read(3'd4, r);
      chk("R8", "status after zero start", r, 32'h5);
      repeat (5) @(negedge clk);
      chk("R8", "reads issued", 32'(n_rd), 32'h0);
      chk("R8", "writes issued", 32'(n_wr), 32'h0);

      // R7: done clear keeps count-zero
      cfg_write(3'd4, 32'h1);
      cfg_read(3'd4, r);
      chk("R7", "status after done clear", r, 32'h4);

      // R7: writes and restart while busy are ignored
      wr_stall = 6;
      clear_logs();
      cfg_write(3'd0, 32'h400);
      cfg_write(3'd1, 32'h5000);
      cfg_write(3'd2, 32'd12);
      cfg_write(3'd3, 32'h21);
      cfg_write(3'd0, 32'hFFF0);
      cfg_write(3'd2, 32'h40);
      cfg_write(3'd3, 32'h03);
      wait_done("R7");
      chk("R7", "writes with busy restart", 32'(n_wr), 32'd3);
      cfg_read(3'd0, r);
      chk("R7", "source untouched by busy write", r, 32'h40C);
      cfg_read(3'd3, r);
      chk("R7", "control untouched by busy write", r, 32'h20);

      // R1: reset in the middle of a transfer
      wr_stall = 8;
      clear_logs();
      cfg_write(3'd2, 32'd16);
      cfg_write(3'd3, 32'h21);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #0.5;
      chk("R1", "rd_req after mid reset", 32'(rd_req), 32'h0);
      chk("R1", "wr_req after mid reset", 32'(wr_req), 32'h0);
      cfg_read(3'd4, r);
      chk("R1", "status after mid reset", r, 32'h0);
      cfg_read(3'd2, r);
      chk("R1", "length after mid reset", r, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule